// File: doc/BRIEF.md
# UART Channel FIFO Controller with DMA Ready Signaling

This block holds the transmit and receive byte queues of one UART channel and the control register that governs them. The host writes characters into the transmit queue and reads received characters from the receive queue. On the other side, the serial shifter pops bytes from the transmit queue and pushes assembled bytes into the receive queue. A single control register turns the queues on, flushes either direction, picks one of two DMA handshake styles and sets the two fill thresholds.

Two active-low ready outputs serve a DMA controller. In single-character style they report "one character can move". In block style they follow the fill thresholds and the free space in the queue. Transmit and receive interrupt requests follow the same thresholds. When the queues are disabled, each direction behaves as a one-character holding register. A receive byte that arrives while the receive queue is full is dropped and flagged.

Top module: `uart_fifo_ctl`

## Requirements
- R1: Each queue keeps up to 64 bytes and delivers them in arrival order. `tx_level` and `rx_level` report the number of stored bytes. A host write to a full transmit queue is dropped.
- R2: After reset, `cfg_rdata` is 0 and both queues are empty. The outputs are then `txrdy_n`=0, `rxrdy_n`=1, `tx_irq`=1, `rx_irq`=0 and `rx_overrun`=0.
- R3: Control bit 0 is the enable, and every write stores it. A write with bit 0 = 0 leaves bit 3, bits 5:4 and bits 7:6 unchanged and flushes nothing, beyond what R5 causes.
- R4: A write with bits 0 and 1 set empties the receive queue. A write with bits 0 and 2 set empties the transmit queue. The other queue is left as it is, and bits 1 and 2 read back as 0.
- R5: A write that changes the enable bit empties both queues. While the enable is 0, each queue holds at most one byte.
- R6: In single-character style (bit 3 = 0, or enable = 0), `txrdy_n` is low exactly when the transmit queue is empty, and `rxrdy_n` is low exactly when the receive queue holds at least one byte.
- R7: In block style (bit 3 = 1 and enable = 1), `txrdy_n` is low exactly when the transmit queue holds fewer than 64 bytes, and `rxrdy_n` is low exactly when the receive level is at or above the receive threshold.
- R8: `rx_irq` is high exactly when the receive level is at or above the receive threshold. With the enable at 1, bits 7:6 select the threshold: 00→8, 01→16, 10→56, 11→60. With the enable at 0 the threshold is 1. The queue keeps accepting bytes past the threshold until it is full.
- R9: `tx_irq` is high exactly when the transmit level is below the transmit threshold. With the enable at 1, bits 5:4 select the threshold: 00→8, 01→16, 10→32, 11→56. With the enable at 0 the threshold is 1.
- R10: A shifter push into a full receive queue is dropped and leaves the stored bytes unchanged. `rx_overrun` is then high for the one cycle after that push.
- R11: `shf_tx_valid` is high exactly when the transmit queue is not empty, and `shf_tx_data` shows the oldest byte. A pop from an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register readback |
| host_tx_wr | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_rd | input | 1 | Host removes the oldest received byte |
| host_rx_data | output | 8 | Oldest received byte |
| shf_tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| shf_tx_data | output | 8 | Oldest transmit byte |
| shf_tx_valid | output | 1 | Transmit queue not empty |
| shf_rx_push | input | 1 | Shifter delivers a received byte |
| shf_rx_data | input | 8 | Received byte |
| txrdy_n | output | 1 | Active-low transmit DMA ready |
| rxrdy_n | output | 1 | Active-low receive DMA ready |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| rx_irq | output | 1 | Receive threshold interrupt request |
| rx_overrun | output | 1 | One-cycle flag for a dropped receive byte |
| tx_level | output | 7 | Transmit queue fill count |
| rx_level | output | 7 | Receive queue fill count |

## Verification
The assertions assume that the strobes are clean single-cycle levels, sampled only at clock edges. They also assume that reads, pops and pushes can arrive in any combination, including against an empty or full queue, so no rule is placed on the inputs beyond reset. The stimulus drives each strobe for exactly one cycle and changes inputs only between edges. It deliberately presses past both queue boundaries, so the drop and empty-pop paths are checked rather than avoided. Threshold sweeps visit every fill level from 0 to 64 under every trigger code in both handshake styles.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned CFG_W    = 8;
    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_RXCLR  = 1;
    localparam int unsigned B_TXCLR  = 2;
    localparam int unsigned B_BLOCK  = 3;
    localparam int unsigned B_TXSEL  = 4;
    localparam int unsigned B_RXSEL  = 6;

    typedef struct packed {
        logic       en;
        logic       block;
        logic [1:0] tx_sel;
        logic [1:0] rx_sel;
    } fifo_cfg_t;

    function automatic int unsigned rx_trig_of(input logic [1:0] sel, input int unsigned depth);
        int unsigned t;
        case (sel)
            2'd0:    t = depth / 8;
            2'd1:    t = depth / 4;
            2'd2:    t = depth - depth / 8;
            default: t = depth - depth / 16;
        endcase
        return t;
    endfunction

    function automatic int unsigned tx_trig_of(input logic [1:0] sel, input int unsigned depth);
        int unsigned t;
        case (sel)
            2'd0:    t = depth / 8;
            2'd1:    t = depth / 4;
            2'd2:    t = depth / 2;
            default: t = depth - depth / 8;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       single,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head_data,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       drop
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic empty, full, pop_ok, push_ok;

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = single ? !empty : (st_q.cnt == LW'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        drop    = push && !push_ok && !clear;
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = st_q.wr + 1'b1;
            if (pop_ok)  st_d.rd = st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clear) mem_q[st_q.wr] <= push_data;
    end

    assign head_data = mem_q[st_q.rd];
    assign level     = st_q.cnt;

    initial begin
        assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R1
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0)); // R4
    AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(level)); // R10
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (level == '0) && !push && !clear) |=> (level == '0)); // R11
endmodule

// File: rtl/fifo_cfg.sv
module fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output fifo_cfg_t         cfg,
    output logic [CFG_W-1:0]  rdata,
    output logic              rx_clr,
    output logic              tx_clr
);
    fifo_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d  = cfg_q;
        rx_clr = 1'b0;
        tx_clr = 1'b0;
        if (we) begin
            cfg_d.en = wdata[B_EN];
            if (wdata[B_EN]) begin
                cfg_d.block  = wdata[B_BLOCK];
                cfg_d.tx_sel = wdata[B_TXSEL +: 2];
                cfg_d.rx_sel = wdata[B_RXSEL +: 2];
                rx_clr       = wdata[B_RXCLR];
                tx_clr       = wdata[B_TXCLR];
            end
            if (wdata[B_EN] != cfg_q.en) begin
                rx_clr = 1'b1;
                tx_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {cfg_q.rx_sel, cfg_q.tx_sel, cfg_q.block, 2'b00, cfg_q.en};

    AST_GATED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[B_EN]) |=> ($stable(cfg_q.block) && $stable(cfg_q.tx_sel) && $stable(cfg_q.rx_sel))); // R3
    AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q.en == $past(wdata[B_EN]))); // R3
endmodule

// File: rtl/dma_ready.sv
module dma_ready
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  fifo_cfg_t                 cfg,
    input  logic [$clog2(DEPTH):0]    tx_level,
    input  logic [$clog2(DEPTH):0]    rx_level,
    output logic                      txrdy_n,
    output logic                      rxrdy_n,
    output logic                      tx_irq,
    output logic                      rx_irq
);
    localparam int unsigned LW = $clog2(DEPTH) + 1;

    logic [LW-1:0] rx_thr, tx_thr;
    logic          burst, rx_hit;

    always_comb begin
        rx_thr  = cfg.en ? LW'(rx_trig_of(cfg.rx_sel, DEPTH)) : LW'(1);
        tx_thr  = cfg.en ? LW'(tx_trig_of(cfg.tx_sel, DEPTH)) : LW'(1);
        burst   = cfg.en && cfg.block;
        rx_hit  = (rx_level >= rx_thr);
        rx_irq  = rx_hit;
        tx_irq  = (tx_level < tx_thr);
        rxrdy_n = burst ? !rx_hit : (rx_level == '0);
        txrdy_n = burst ? (tx_level == LW'(DEPTH)) : (tx_level != '0);
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    input  logic                     host_tx_wr,
    input  logic [WIDTH-1:0]         host_tx_data,
    input  logic                     host_rx_rd,
    output logic [WIDTH-1:0]         host_rx_data,
    input  logic                     shf_tx_pop,
    output logic [WIDTH-1:0]         shf_tx_data,
    output logic                     shf_tx_valid,
    input  logic                     shf_rx_push,
    input  logic [WIDTH-1:0]         shf_rx_data,
    output logic                     txrdy_n,
    output logic                     rxrdy_n,
    output logic                     tx_irq,
    output logic                     rx_irq,
    output logic                     rx_overrun,
    output logic [$clog2(DEPTH):0]   tx_level,
    output logic [$clog2(DEPTH):0]   rx_level
);
    localparam int unsigned LW = $clog2(DEPTH) + 1;

    fifo_cfg_t cfg;
    logic      rx_clr, tx_clr, rx_drop, tx_drop;
    logic      ovr_d, ovr_q;

    fifo_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .rdata  (cfg_rdata),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clr),
        .single    (!cfg.en),
        .push      (host_tx_wr),
        .push_data (host_tx_data),
        .pop       (shf_tx_pop),
        .head_data (shf_tx_data),
        .level     (tx_level),
        .drop      (tx_drop)
    );

    byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clr),
        .single    (!cfg.en),
        .push      (shf_rx_push),
        .push_data (shf_rx_data),
        .pop       (host_rx_rd),
        .head_data (host_rx_data),
        .level     (rx_level),
        .drop      (rx_drop)
    );

    dma_ready #(.DEPTH(DEPTH)) u_rdy (
        .cfg      (cfg),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .txrdy_n  (txrdy_n),
        .rxrdy_n  (rxrdy_n),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

    always_comb begin
        ovr_d = rx_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign rx_overrun   = ovr_q;
    assign shf_tx_valid = (tx_level != '0);

    AST_RXIRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_level != '0)); // R8
    AST_TXIRQ_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && cfg.en && cfg.block) |-> !txrdy_n); // R9
    AST_DISABLED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> ((rx_level <= LW'(1)) && (tx_level <= LW'(1)))); // R5
    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drop && cfg.en) |-> (tx_level == LW'(DEPTH))); // R1
    AST_OVERRUN_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_level) != '0)); // R10
endmodule

// File: tb/uart_fifo_ctl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       host_tx_wr = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_rx_rd = 1'b0;
    logic [7:0] host_rx_data;
    logic       shf_tx_pop = 1'b0;
    logic [7:0] shf_tx_data;
    logic       shf_tx_valid;
    logic       shf_rx_push = 1'b0;
    logic [7:0] shf_rx_data = '0;
    logic       txrdy_n, rxrdy_n, tx_irq, rx_irq, rx_overrun;
    logic [6:0] tx_level, rx_level;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    uart_fifo_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .shf_tx_pop(shf_tx_pop), .shf_tx_data(shf_tx_data), .shf_tx_valid(shf_tx_valid),
        .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .rx_overrun(rx_overrun), .tx_level(tx_level), .rx_level(rx_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        cfg_we = 1'b0; host_tx_wr = 1'b0; host_rx_rd = 1'b0;
        shf_tx_pop = 1'b0; shf_rx_push = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v; cyc();
    endtask

    task automatic rx_push(input logic [7:0] v);
        shf_rx_push = 1'b1; shf_rx_data = v; cyc();
    endtask

    task automatic tx_write(input logic [7:0] v);
        host_tx_wr = 1'b1; host_tx_data = v; cyc();
    endtask

    function automatic int rx_thr(input int sel);
        return (sel == 0) ? 8 : (sel == 1) ? 16 : (sel == 2) ? 56 : 60;
    endfunction

    function automatic int tx_thr(input int sel);
        return (sel == 0) ? 8 : (sel == 1) ? 16 : (sel == 2) ? 32 : 56;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 cfg_rdata", cfg_rdata, 0);
        chk("R2 txrdy_n", txrdy_n, 0);
        chk("R2 rxrdy_n", rxrdy_n, 1);
        chk("R2 tx_irq", tx_irq, 1);
        chk("R2 rx_irq", rx_irq, 0);
        chk("R2 rx_overrun", rx_overrun, 0);
        chk("R2 tx_level", tx_level, 0);
        chk("R2 rx_level", rx_level, 0);
        chk("R11 valid empty", shf_tx_valid, 0);

        // R5/R6 disabled queues hold one byte
        rx_push(8'hA5);
        chk("R5 rx one", rx_level, 1);
        chk("R6 rxrdy_n", rxrdy_n, 0);
        chk("R8 rx_irq thr1", rx_irq, 1);
        rx_push(8'h5A);
        chk("R10 overrun", rx_overrun, 1);
        chk("R5 rx still one", rx_level, 1);
        cyc();
        chk("R10 overrun one cycle", rx_overrun, 0);
        chk("R10 data kept", host_rx_data, 8'hA5);
        host_rx_rd = 1'b1; cyc();
        chk("R6 rx empty", rx_level, 0);
        tx_write(8'h11);
        chk("R6 txrdy_n", txrdy_n, 1);
        chk("R9 tx_irq thr1", tx_irq, 0);
        tx_write(8'h22);
        chk("R5 tx one", tx_level, 1);
        chk("R11 head", shf_tx_data, 8'h11);
        cfg_write(8'h01);
        chk("R5 enable flush", tx_level, 0);

        // R3 gated fields
        cfg_write(8'hF9);
        chk("R3 readback", cfg_rdata, 8'hF9);
        cfg_write(8'h00);
        chk("R3 fields kept", cfg_rdata, 8'hF8);
        rx_push(8'h33);
        cfg_write(8'h06);
        chk("R3 no flush", rx_level, 1);
        chk("R3 fields kept2", cfg_rdata, 8'hF8);
        cfg_write(8'h01);
        chk("R3 rewrite", cfg_rdata, 8'h01);
        chk("R5 flush on enable", rx_level, 0);

        // R4 isolation
        tx_write(8'h01); tx_write(8'h02); tx_write(8'h03);
        rx_push(8'h44);
        cfg_write(8'h03);
        chk("R4 rx cleared", rx_level, 0);
        chk("R4 tx kept", tx_level, 3);
        chk("R4 bit1 reads 0", cfg_rdata, 8'h01);

        // R7/R8 receive sweeps
        for (int m = 0; m < 2; m++) begin
            for (int sel = 0; sel < 4; sel++) begin
                cfg_write(8'(1 | 2 | (m << 3) | (sel << 6)));
                for (int k = 0; k <= 64; k++) begin
                    chk("R1 rx level", rx_level, k);
                    chk("R8 rx_irq", rx_irq, (k >= rx_thr(sel)) ? 1 : 0);
                    if (m == 1) chk("R7 rxrdy_n", rxrdy_n, (k >= rx_thr(sel)) ? 0 : 1);
                    else        chk("R6 rxrdy_n", rxrdy_n, (k == 0) ? 1 : 0);
                    if (k < 64) rx_push(8'((k * 5 + sel) & 8'hFF));
                end
                rx_push(8'hEE);
                chk("R10 full overrun", rx_overrun, 1);
                chk("R10 level held", rx_level, 64);
            end
        end

        // R4 transmit flush leaves full receive queue
        cfg_write(8'h05);
        chk("R4 tx cleared", tx_level, 0);
        chk("R4 rx kept", rx_level, 64);
        chk("R4 bit2 reads 0", cfg_rdata, 8'h01);
        for (int k = 0; k < 64; k++) begin
            chk("R1 rx order", host_rx_data, (k * 5 + 3) & 8'hFF);
            host_rx_rd = 1'b1; cyc();
        end
        chk("R1 rx drained", rx_level, 0);

        // R7/R9 transmit sweeps
        for (int m = 0; m < 2; m++) begin
            for (int sel = 0; sel < 4; sel++) begin
                cfg_write(8'(1 | 4 | (m << 3) | (sel << 4)));
                for (int k = 0; k <= 64; k++) begin
                    chk("R1 tx level", tx_level, k);
                    chk("R9 tx_irq", tx_irq, (k < tx_thr(sel)) ? 1 : 0);
                    if (m == 1) chk("R7 txrdy_n", txrdy_n, (k == 64) ? 1 : 0);
                    else        chk("R6 txrdy_n", txrdy_n, (k != 0) ? 1 : 0);
                    if (k < 64) tx_write(8'((k * 9 + sel) & 8'hFF));
                end
                tx_write(8'hDD);
                chk("R1 tx drop", tx_level, 64);
            end
        end
        for (int k = 0; k < 64; k++) begin
            chk("R11 valid", shf_tx_valid, 1);
            chk("R1 tx order", shf_tx_data, (k * 9 + 3) & 8'hFF);
            shf_tx_pop = 1'b1; cyc();
        end
        chk("R11 valid low", shf_tx_valid, 0);
        shf_tx_pop = 1'b1; cyc();
        chk("R11 empty pop", tx_level, 0);
        tx_write(8'h7C);
        chk("R11 after empty pop", shf_tx_data, 8'h7C);
        chk("R11 level one", tx_level, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule